// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit up/down timer that sweeps from zero to its maximum and back, tracing a symmetric triangle. Each time the count advances, it is compared with a compare value. On a match the block drives one waveform pin high or low. The choice depends on whether the count is on its rising or its falling slope. The result is a centre-aligned PWM signal whose duty cycle follows the compare value.

A clock-select field sets the count rate. The counter can be stopped, stepped on every clock, or stepped at one of six slower rates taken from a free-running divider. A small register port lets software read and write the count, the compare value, the output mode and the clock select. A one-cycle flag reports each compare match so that it can serve as an interrupt request.

The compare value is double-buffered, so a new duty cycle only applies from the next turn at the maximum. A write to the count masks the match on the following step. A compare value equal to the maximum is handled by a dedicated rule, so that the output does not glitch at the peak.

Top module: `tri_pwm_timer`

## Requirements
- R1: After reset, all four registers read zero, the count direction is rising, `wave_out`, `wave_oe` and `cmp_flag` are low, and the divider is at zero.
- R2: The clock-select register (address 3, bits [2:0]) sets when the count steps:
  - Value 0 stops the count.
  - Value 1 steps it on every clock.
  - Values 2 to 7 step it only on clocks where the low 3, 5, 6, 7, 8 or 10 bits (in that order) of a 10-bit divider are zero. The divider is zero after reset and increments on every clock.
- R3: On each step the count moves by one. It rises 0,1,…,255, then falls 254,…,1,0, then rises again, so each extreme appears for one step and a full period is 510 steps. Address 0 reads the count.
- R4: When the output mode (address 2, bits [1:0]) is 00 or 01, `wave_oe` is low, `wave_out` is low, and the internal output level is frozen.
- R5: In mode 10, a match on the rising slope drives the output low and a match on the falling slope drives it high.
- R6: In mode 11, a match on the rising slope drives the output high and a match on the falling slope drives it low.
- R7: When the active compare value is 255 and mode bit 1 is set, the normal match action is not used. Instead, the falling-slope action of the mode is applied on the step taken at count 255.
- R8: A write to the count (address 0) takes priority over a step in the same cycle. It suppresses the match flag and the output action on the next step.
- R9: A write to the compare register (address 1) is read back at once. It becomes the active compare value only on a step taken at count 255, after that step's own compare.
- R10: `cmp_flag` is high for exactly the cycle after a step on which the count equals the active compare value (unless suppressed by R8). It stays high for that cycle whatever the output mode.
- R11: Writes to addresses 2 and 3 store the mode and clock select. Those registers read back zero-extended at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 count, 1 compare, 2 mode, 3 clock select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| wave_out | output | 1 | PWM waveform, low while disconnected |
| wave_oe | output | 1 | High when the waveform owns the pin |
| cmp_flag | output | 1 | One-cycle compare-match pulse |

## Verification
Two collisions matter most.

The first is a software write to the count landing in the same cycle as a counter step. With the clock select at 1 every cycle is a step, so random writes always collide. The write must win, and the next step must produce neither a flag nor an output change.

The second is the compare reload at the peak landing on the same step as the peak-value special rule. This is provoked by writing 255 or other values to the compare register at random times while the count runs. The bench's model then judges which compare value each step used, and whether the special rule or the normal match applied.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_RSVD   = 2'b01,
        OUT_CLR_UP = 2'b10,
        OUT_SET_UP = 2'b11
    } out_mode_e;

    typedef enum logic [2:0] {
        CS_STOP    = 3'd0,
        CS_DIV1    = 3'd1,
        CS_DIV8    = 3'd2,
        CS_DIV32   = 3'd3,
        CS_DIV64   = 3'd4,
        CS_DIV128  = 3'd5,
        CS_DIV256  = 3'd6,
        CS_DIV1024 = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        RA_COUNT = 2'd0,
        RA_CMP   = 2'd1,
        RA_MODE  = 2'd2,
        RA_CSEL  = 2'd3
    } reg_addr_e;

    // Compare event seen on one cycle
    typedef struct packed {
        logic fire;    // step that is not masked
        logic hit;     // count equals active compare
        logic at_top;  // count at maximum
        logic rising;  // slope of the current count
    } cmp_evt_t;

    // Divider bits that must be zero for a step
    function automatic logic [PRE_W-1:0] tap_mask(clk_sel_e cs);
        case (cs)
            CS_DIV8:    return PRE_W'(10'h007);
            CS_DIV32:   return PRE_W'(10'h01F);
            CS_DIV64:   return PRE_W'(10'h03F);
            CS_DIV128:  return PRE_W'(10'h07F);
            CS_DIV256:  return PRE_W'(10'h0FF);
            CS_DIV1024: return PRE_W'(10'h3FF);
            default:    return '0;
        endcase
    endfunction

    // Output level driven by a match on the given slope
    function automatic logic slope_level(out_mode_e m, logic rising);
        return rising ? (m == OUT_SET_UP) : (m == OUT_CLR_UP);
    endfunction

endpackage

// File: rtl/tri_pwm_prescale.sv
module tri_pwm_prescale
    import tri_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    output logic     tick
);

    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        case (sel)
            CS_STOP: tick = 1'b0;
            CS_DIV1: tick = 1'b1;
            default: tick = ((div_q & tap_mask(sel)) == '0);
        endcase
    end

endmodule

// File: rtl/tri_pwm_counter.sv
module tri_pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             rising,
    output logic             blocked
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic             blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
            blk_q <= 1'b0;
        end else begin
            if (tick) begin
                blk_q <= 1'b0;
                if (up_q) begin
                    if (cnt_q == TOP) begin
                        cnt_q <= TOP - 1'b1;
                        up_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == BOT) begin
                        cnt_q <= BOT + 1'b1;
                        up_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
            // software write wins over the step
            if (load) begin
                cnt_q <= load_val;
                blk_q <= 1'b1;
            end
        end
    end

    assign count   = cnt_q;
    assign rising  = up_q;
    assign blocked = blk_q;

    // R3: each unloaded step moves the count by exactly one
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));

    // R2: no step and no write leaves the count alone
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/tri_pwm_compare.sv
module tri_pwm_compare
    import tri_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             rising,
    input  logic             blocked,
    input  out_mode_e        mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_buf,
    output logic             wave,
    output logic             match
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;
    logic             wave_q;
    logic             match_q;
    cmp_evt_t         evt;
    logic             top_rule;

    always_comb begin
        evt.fire   = tick && !blocked;
        evt.hit    = (count == act_q);
        evt.at_top = (count == TOP);
        evt.rising = rising;
        top_rule   = mode[1] && (act_q == TOP) && evt.at_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            act_q   <= '0;
            wave_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            if (cmp_wr) buf_q <= cmp_wdata;
            if (tick && evt.at_top) act_q <= buf_q;
            match_q <= evt.fire && evt.hit;
            if (evt.fire && mode[1]) begin
                if (top_rule)     wave_q <= slope_level(mode, 1'b0);
                else if (evt.hit) wave_q <= slope_level(mode, evt.rising);
            end
        end
    end

    assign cmp_buf = buf_q;
    assign wave    = wave_q;
    assign match   = match_q;

    // R9: active compare only changes on a step at the maximum
    assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
        !(tick && evt.at_top) |=> $stable(act_q));

    // R4: disconnected modes freeze the output level
    assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |=> $stable(wave_q));

    // R8: a masked step never raises the flag
    assert_block_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && blocked) |=> !match_q);

endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
    import tri_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             wave_out,
    output logic             wave_oe,
    output logic             cmp_flag
);

    out_mode_e        mode_q;
    clk_sel_e         sel_q;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             rising;
    logic             blocked;
    logic [CNT_W-1:0] cmp_buf;
    logic             wave;
    logic             wr_count;
    logic             wr_cmp;
    reg_addr_e        ra;

    assign ra       = reg_addr_e'(bus_addr);
    assign wr_count = bus_wr && (ra == RA_COUNT);
    assign wr_cmp   = bus_wr && (ra == RA_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OUT_OFF;
            sel_q  <= CS_STOP;
        end else if (bus_wr) begin
            if (ra == RA_MODE) mode_q <= out_mode_e'(bus_wdata[1:0]);
            if (ra == RA_CSEL) sel_q  <= clk_sel_e'(bus_wdata[2:0]);
        end
    end

    tri_pwm_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel_q),
        .tick (tick)
    );

    tri_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_count),
        .load_val (bus_wdata),
        .count    (count),
        .rising   (rising),
        .blocked  (blocked)
    );

    tri_pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .count     (count),
        .rising    (rising),
        .blocked   (blocked),
        .mode      (mode_q),
        .cmp_wr    (wr_cmp),
        .cmp_wdata (bus_wdata),
        .cmp_buf   (cmp_buf),
        .wave      (wave),
        .match     (cmp_flag)
    );

    always_comb begin
        case (ra)
            RA_COUNT: bus_rdata = count;
            RA_CMP:   bus_rdata = cmp_buf;
            RA_MODE:  bus_rdata = CNT_W'(mode_q);
            default:  bus_rdata = CNT_W'(sel_q);
        endcase
    end

    assign wave_oe  = mode_q[1];
    assign wave_out = wave_oe & wave;

    // R2: a stopped timer holds its count unless software writes it
    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_q == CS_STOP && !wr_count) |=> $stable(count));

endmodule

// File: tb/tri_pwm_timer_tb.sv
module tri_pwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       wave_out, wave_oe, cmp_flag;

    always #10 clk = ~clk;

    tri_pwm_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .wave_out  (wave_out),
        .wave_oe   (wave_oe),
        .cmp_flag  (cmp_flag)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [9:0] m_pre;
    logic [7:0] m_cnt, m_buf, m_act;
    logic       m_up, m_blk, m_wave, m_match;
    logic [1:0] m_mode;
    logic [2:0] m_sel;

    function automatic logic exp_tick(logic [2:0] s, logic [9:0] p);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return p[2:0] == 0;
            3'd3: return p[4:0] == 0;
            3'd4: return p[5:0] == 0;
            3'd5: return p[6:0] == 0;
            3'd6: return p[7:0] == 0;
            default: return p == 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_buf;
            2'd2: return {6'd0, m_mode};
            default: return {5'd0, m_sel};
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pre = '0; m_cnt = '0; m_buf = '0; m_act = '0;
        m_up = 1'b1; m_blk = 1'b0; m_wave = 1'b0; m_match = 1'b0;
        m_mode = '0; m_sel = '0;
    endtask

    task automatic model_step(logic [1:0] a, logic w, logic [7:0] d);
        logic       t;
        logic [7:0] nc, nb, na;
        logic       nu, nblk, nw, nm;
        logic [1:0] nmode;
        logic [2:0] nsel;
        t = exp_tick(m_sel, m_pre);
        nc = m_cnt; nb = m_buf; na = m_act; nu = m_up; nblk = m_blk;
        nw = m_wave; nm = 1'b0; nmode = m_mode; nsel = m_sel;
        if (t) begin
            nm = !m_blk && (m_cnt == m_act);
            if (!m_blk && m_mode[1]) begin
                if (m_act == 8'hFF && m_cnt == 8'hFF) nw = (m_mode == 2'b10);
                else if (m_cnt == m_act) nw = m_up ? (m_mode == 2'b11) : (m_mode == 2'b10);
            end
            if (m_cnt == 8'hFF) na = m_buf;
            if (m_up) begin
                if (m_cnt == 8'hFF) begin nc = 8'hFE; nu = 1'b0; end
                else nc = m_cnt + 8'd1;
            end else begin
                if (m_cnt == 8'h00) begin nc = 8'h01; nu = 1'b1; end
                else nc = m_cnt - 8'd1;
            end
            nblk = 1'b0;
        end
        if (w) begin
            case (a)
                2'd0: begin nc = d; nblk = 1'b1; end
                2'd1: nb = d;
                2'd2: nmode = d[1:0];
                default: nsel = d[2:0];
            endcase
        end
        m_cnt = nc; m_buf = nb; m_act = na; m_up = nu; m_blk = nblk;
        m_wave = nw; m_match = nm; m_mode = nmode; m_sel = nsel;
        m_pre = m_pre + 10'd1;
    endtask

    task automatic compare_outs(logic [1:0] a);
        string wreq;
        logic  ew;
        ew = m_mode[1] & m_wave;
        if (!m_mode[1])            wreq = "R4 wave low";
        else if (m_act == 8'hFF)   wreq = "R7 top rule";
        else if (m_mode == 2'b10)  wreq = "R5 mode 10";
        else                       wreq = "R6 mode 11";
        check(wave_oe === m_mode[1], "R4 enable", 32'(wave_oe), 32'(m_mode[1]));
        check(wave_out === ew, wreq, 32'(wave_out), 32'(ew));
        check(cmp_flag === m_match, "R10 flag", 32'(cmp_flag), 32'(m_match));
        if (a == 2'd0)      check(rdata === exp_read(a), "R3 count", 32'(rdata), 32'(exp_read(a)));
        else if (a == 2'd1) check(rdata === exp_read(a), "R9 compare read", 32'(rdata), 32'(exp_read(a)));
        else                check(rdata === exp_read(a), "R11 control read", 32'(rdata), 32'(exp_read(a)));
    endtask

    // one clock: drive at negedge, check, advance model, wait next negedge
    task automatic cycle(logic [1:0] a, logic w, logic [7:0] d);
        addr = a; wr = w; wdata = d;
        #1;
        compare_outs(a);
        model_step(a, w, d);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(2'd0, 1'b0, 8'h00);
    endtask

    initial begin
        int unsigned seed_junk;
        seed_junk = $urandom(32'd7321);
        rst = 1'b1; addr = '0; wr = 1'b0; wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #1;
            check(rdata === 8'h00, "R1 register reset", 32'(rdata), 0);
        end
        check(wave_out === 1'b0, "R1 wave low", 32'(wave_out), 0);
        check(wave_oe === 1'b0, "R1 enable low", 32'(wave_oe), 0);
        check(cmp_flag === 1'b0, "R1 flag low", 32'(cmp_flag), 0);
        rst = 1'b0;

        // R2: stopped counter does not move
        idle(30);
        addr = 2'd0; #1;
        check(rdata === 8'h00, "R2 stopped", 32'(rdata), 0);

        // R11: control registers, then divide-by-8
        cycle(2'd2, 1'b1, 8'h02);
        cycle(2'd3, 1'b1, 8'h02);
        cycle(2'd2, 1'b0, 8'h00);
        cycle(2'd3, 1'b0, 8'h00);
        idle(200);

        // R5: full speed, compare 0x40
        cycle(2'd3, 1'b1, 8'h01);
        cycle(2'd1, 1'b1, 8'h40);
        cycle(2'd1, 1'b0, 8'h00);
        idle(1100);
        // R6
        cycle(2'd2, 1'b1, 8'h03);
        idle(1100);
        // R7: compare at maximum, both polarities
        cycle(2'd1, 1'b1, 8'hFF);
        idle(1100);
        cycle(2'd2, 1'b1, 8'h02);
        idle(1100);
        // compare at zero
        cycle(2'd1, 1'b1, 8'h00);
        idle(600);
        // R4: reserved mode disconnects
        cycle(2'd2, 1'b1, 8'h01);
        idle(600);

        // R8: write count onto the compare value, next step must be masked
        cycle(2'd2, 1'b1, 8'h02);
        cycle(2'd1, 1'b1, 8'h80);
        idle(600);
        cycle(2'd0, 1'b1, 8'h80);
        cycle(2'd0, 1'b0, 8'h00);
        check(cmp_flag === 1'b0, "R8 masked step", 32'(cmp_flag), 0);
        idle(20);

        // random phase
        for (int i = 0; i < 8000; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(3, 0));
            d = 8'($urandom_range(255, 0));
            if ($urandom_range(15, 0) == 0) begin
                if (a == 2'd3) d = ($urandom_range(9, 0) < 8) ? 8'h01 : {5'd0, d[2:0]};
                if (a == 2'd1 && d[0]) d = 8'hFF;
                cycle(a, 1'b1, d);
            end else begin
                cycle(a, 1'b0, 8'h00);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule